// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A read or write command presents a start column. The burst length code and the ordering type come from the mode register. The block then steps through the columns of the burst one clock at a time. For each beat it flags that the beat is valid and marks the final beat. Data storage and command decoding live elsewhere. The block only answers "which column is this beat".

Two orderings are supported:
- Sequential counting wraps inside the aligned group of the burst length.
- Interleaved ordering XORs the start column with the beat number.

A full-page code runs through the whole row and wraps at its end until a stop or a new command ends it. A mode bit can force writes to a single beat while reads keep the programmed length. A new command may replace a running burst on any cycle. A stop request ends the burst at once. A low clock enable freezes the whole sequence.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `beat_valid` and `last_beat` are 0 and `col` is 0.
- R2: When `cke` and `start` are 1 at a clock edge, the next cycle shows `beat_valid`=1 and `col`=`start_col`.
- R3: `len_code` selects the beat count: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 give 1 beat.
- R4: With `burst_type`=0 (sequential), beat i has column (start + i) mod L placed within the L-aligned group that contains start. For example, L=4 from column 1 gives 1,2,3,0.
- R5: With `burst_type`=1 (interleaved), beat i has column start XOR i. For example, L=8 from column 5 gives 5,4,7,6,1,0,3,2.
- R6: With code 3'b111, beat i has column (start + i) mod 2^COL_W whatever `burst_type` is. `last_beat` is never raised, and the burst runs until it is stopped or restarted.
- R7: When `wr_single`=1 and `is_write`=1, the burst is one beat. When `wr_single`=1 and `is_write`=0, the read keeps its programmed length.
- R8: `start` restarts the burst on any cycle, including mid-burst. It takes priority over `stop` in the same cycle.
- R9: `stop` without `start` at an edge where `cke`=1 drops `beat_valid` in the next cycle.
- R10: At an edge where `cke`=0, the outputs stay unchanged, and `start` and `stop` have no effect.
- R11: `last_beat` is 1 exactly on the final beat of a burst that is not full page. After that beat, `beat_valid` drops unless a new `start` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; 0 freezes the sequence |
| start | input | 1 | Read or write column command |
| start_col | input | COL_W | Start column of the command |
| is_write | input | 1 | 1 for a write command, 0 for a read |
| len_code | input | 3 | Burst length code from the mode register |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| wr_single | input | 1 | Forces writes to a single beat |
| stop | input | 1 | Ends the running burst |
| col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A burst beat is in progress |
| last_beat | output | 1 | Current beat is the final one |

## Verification
The bench builds the block with COL_W=8, which gives a 256-column page. With that size, a full-page burst started near the top of the row wraps past column 0 within a few cycles. Random start columns also hit both page edges and every alignment of the 2-, 4- and 8-beat groups. Random bursts mix restarts, stops and clock-enable gaps at arbitrary beats. This covers interrupts and freezes at the first, middle and last beat of each length and ordering.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic [2:0]       len_code,
  input  logic             burst_type,
  input  logic             wr_single,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             last_beat
);
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             full_q, ilv_q, valid_q;

  function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
    case (code)
      3'b001:  return COL_W'(1);
      3'b010:  return COL_W'(3);
      3'b011:  return COL_W'(7);
      default: return '0;
    endcase
  endfunction

  wire              single   = is_write & wr_single;
  wire              new_full = (len_code == 3'b111) & ~single;
  wire [COL_W-1:0]  new_mask = single ? '0 : (new_full ? '1 : len_mask(len_code));
  wire              at_end   = ~full_q & (idx_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (cke) begin
      if (start) begin
        base_q  <= start_col;
        idx_q   <= '0;
        mask_q  <= new_mask;
        full_q  <= new_full;
        ilv_q   <= burst_type & ~new_full;
        valid_q <= 1'b1;
      end else if (valid_q) begin
        if (stop | at_end) valid_q <= 1'b0;
        else               idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign col        = ilv_q ? (base_q ^ idx_q)
                            : ((base_q & ~mask_q) | ((base_q + idx_q) & mask_q));
  assign beat_valid = valid_q;
  assign last_beat  = valid_q & at_end;
endmodule

module sdram_burst_colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             last_beat
);
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start |=> beat_valid && col == $past(start_col));

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cke && stop && !start |=> !beat_valid);

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(col) && $stable(beat_valid) && $stable(last_beat));

  p_last_in_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  p_last_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cke && last_beat && !start |=> !beat_valid);

  p_restart_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start && stop |=> beat_valid);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .stop(stop),
  .start_col(start_col), .col(col), .beat_valid(beat_valid), .last_beat(last_beat)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 0, rst_n = 0;
  logic cke = 1, start = 0, is_write = 0, burst_type = 0, wr_single = 0, stop = 0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic [COL_W-1:0] col;
  logic beat_valid, last_beat;

  int errors = 0, checks = 0, cycles = 0;
  bit e_valid = 0, e_full = 0, e_ilv = 0;
  int e_base = 0, e_len = 1, e_i = 0;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .start_col(start_col),
    .is_write(is_write), .len_code(len_code), .burst_type(burst_type),
    .wr_single(wr_single), .stop(stop), .col(col), .beat_valid(beat_valid),
    .last_beat(last_beat)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    if (e_full) return (e_base + e_i) % PAGE;
    if (e_ilv)  return e_base ^ e_i;
    return (e_base / e_len) * e_len + (e_base + e_i) % e_len;
  endfunction

  // one clock: inputs already driven; update model at edge, compare after it
  task automatic step(input string req);
    @(posedge clk);
    if (cke) begin
      if (start) begin
        e_valid = 1; e_base = int'(start_col); e_i = 0;
        if (is_write && wr_single) begin e_full = 0; e_len = 1; end
        else begin
          e_full = (len_code == 3'b111);
          e_len  = e_full ? PAGE : code_len(len_code);
        end
        e_ilv = burst_type && !e_full;
      end else if (e_valid) begin
        if (stop || (!e_full && e_i == e_len - 1)) e_valid = 0;
        else e_i = (e_i + 1) % PAGE;
      end
    end
    #3;
    chk(beat_valid == e_valid, req, beat_valid, e_valid);
    chk(last_beat == (e_valid && !e_full && e_i == e_len - 1), req, last_beat,
        e_valid && !e_full && e_i == e_len - 1);
    if (e_valid) chk(int'(col) == exp_col(), req, col, exp_col());
  endtask

  task automatic cmd(input int sc, input logic [2:0] lc, input bit bt, input bit wr,
                     input bit ws, input string req);
    start = 1; start_col = COL_W'(sc); len_code = lc; burst_type = bt;
    is_write = wr; wr_single = ws;
    step(req);
    start = 0;
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) step(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #25;
    chk(beat_valid == 0 && last_beat == 0 && col == 0, "R1", {beat_valid, last_beat, col}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R4 sequential wrap: 1,2,3,0
    cmd(1, 3'b010, 0, 0, 0, "R2 R4"); idle(4, "R4 R11");
    // R5 interleaved: 5,4,7,6,1,0,3,2
    cmd(5, 3'b011, 1, 0, 0, "R2 R5"); idle(8, "R5 R11");
    // R3 every code including reserved
    for (int c = 0; c < 7; c++) begin
      cmd(6 + c * 3, 3'(c), c[0], 0, 0, "R3"); idle(9, "R3 R11");
    end
    // R6 full page wrapping past column 0, then R9 stop
    cmd(PAGE - 3, 3'b111, 1, 0, 0, "R6"); idle(8, "R6");
    stop = 1; step("R9"); stop = 0; idle(2, "R9");
    // R7 single-beat writes, reads keep length
    cmd(9, 3'b010, 0, 1, 1, "R7"); idle(2, "R7");
    cmd(9, 3'b010, 0, 0, 1, "R7"); idle(5, "R7");
    cmd(9, 3'b111, 0, 1, 1, "R7"); idle(2, "R7");
    // R8 restart mid-burst and start over stop
    cmd(16, 3'b011, 0, 0, 0, "R8"); idle(2, "R8");
    stop = 1; cmd(42, 3'b010, 1, 0, 0, "R8"); stop = 0; idle(5, "R8");
    // R10 freeze with start and stop ignored
    cmd(20, 3'b011, 0, 0, 0, "R10"); idle(2, "R10");
    cke = 0; start = 1; stop = 1; start_col = 8'd99; idle(3, "R10");
    start = 0; stop = 0; cke = 1; idle(7, "R10 R11");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      start      = ($urandom_range(0, 5) == 0);
      stop       = ($urandom_range(0, 9) == 0);
      cke        = ($urandom_range(0, 7) != 0);
      start_col  = COL_W'($urandom);
      len_code   = 3'($urandom);
      burst_type = 1'($urandom);
      is_write   = 1'($urandom);
      wr_single  = ($urandom_range(0, 3) == 0);
      step("R8 R10");
    end
    summary();
  end
endmodule